// File: doc/BRIEF.md
# Dual-Mode Pulse-per-Second Generator

This block is the digital heart of a temperature-compensated oscillator's timing output. A phase accumulator clocked by the crystal's overtone clock adds a software-supplied correction word on every edge. Its top bit is a correction clock that, mixed with the overtone frequency outside this block, yields a precise 10 MHz reference. A single mode input chooses how the once-per-second pulse is produced.

In frequency mode, a two-stage counter chain clocked by the 10 MHz reference makes the pulse. In the low-power timing mode, the 10 MHz chain is held idle and the external loop is told to switch off. The pulse then comes from a counter in the overtone domain. That counter advances by one each overtone cycle plus one more on every accumulator wrap, so it runs at the corrected rate. A periodic update request tells the controlling software when to supply a fresh correction word. The interval is longer in timing mode to save power.

Top module: `dual_pps_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `pps`, `synth_clk` and `upd_req` are 0, and `pll_en` and `ref_div_en` are 1 (frequency mode).
- R2: The active correction word is added to an ACC_W-bit phase accumulator on every `clk_ovt` rising edge, and `synth_clk` is the accumulator's top bit. With word 2^30 and ACC_W = 32, `synth_clk` has a period of 4 `clk_ovt` cycles.
- R3: `corr_load` captures `corr_word` into a shadow register. The shadow is made active only on an accumulator wrap (carry out), or at once if the active word is zero. The active word never changes at any other time.
- R4: In frequency mode, one pulse starts every DIV_A*DIV_B `clk_ref` cycles.
- R5: In timing mode, a counter gains 1 per `clk_ovt` cycle plus 1 per accumulator wrap. A pulse starts each time it reaches TIME_TC, with the excess carried over. Two terminal counts never occur on adjacent cycles.
- R6: In timing mode, `pll_en` and `ref_div_en` are 0 and the reference divider is held at zero with no output. In frequency mode, the timing-path counter is held at zero with no output.
- R7: The mode input is one bit: 0 selects frequency mode and 1 selects timing mode.
- R8: `upd_req` is a one-cycle pulse in the `clk_ovt` domain, issued every UPD_FREQ accumulator wraps in frequency mode and every UPD_TIME wraps in timing mode. It is only ever issued on the cycle after a wrap.
- R9: After a mode change, the newly selected path starts from zero, so its first pulse comes no earlier than one full period of that path after the switch.
- R10: Each pulse on `pps` is high for exactly PULSE_W cycles of the clock of the path that made it, starting the cycle after that path's terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ovt | input | 1 | Crystal overtone clock; clocks the accumulator and timing path |
| clk_ref | input | 1 | 10 MHz reference clock; clocks the divider chain |
| rst | input | 1 | Synchronous active-high reset, held across several cycles of both clocks |
| corr_word | input | ACC_W | Correction word (phase increment) |
| corr_load | input | 1 | Strobe that captures `corr_word` into the shadow register |
| mode_time | input | 1 | 0 = frequency mode, 1 = timing mode; synchronous to `clk_ovt` |
| synth_clk | output | 1 | Correction clock, top bit of the phase accumulator |
| pps | output | 1 | Once-per-second pulse, stretched to PULSE_W cycles |
| pll_en | output | 1 | Enable for the external phase-locked loop, low in timing mode |
| ref_div_en | output | 1 | Enable of the 10 MHz divider chain, low in timing mode |
| upd_req | output | 1 | One-cycle request for a new correction word |

## Verification
On every cycle, assertions check four things. The active word changes only on a wrap or from zero. An update request always follows a wrap. Each idle path stays at zero and silent. Every terminal count is followed by a high pulse, and a low pulse stays low without a new count. Only the bench scenarios can show the quantities the software and the system see. These are the actual pulse periods in each mode, the correction clock period for a given word, and the pulse width measured in time. They also include the spacing of update requests in each mode and the delay from a mode switch to the first pulse, which spans the crossing into the reference domain.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;

    typedef enum logic {
        MODE_FREQ = 1'b0,
        MODE_TIME = 1'b1
    } pps_mode_e;

    typedef struct packed {
        logic carry;
        logic req;
    } acc_evt_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pps_stretch.sv
`timescale 1ns/1ps
module pps_stretch #(
    parameter int unsigned WIDTH = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic pulse
);
    localparam int unsigned CW = pps_pkg::cnt_w(WIDTH + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(WIDTH);

    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hold_cnt <= '0;
        end else if (tick) begin
            hold_cnt <= LOAD_V;
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign pulse = (hold_cnt != '0);

    AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> pulse);  // R10
    AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!pulse && !tick) |=> !pulse);  // R10

endmodule

// File: rtl/pps_dds.sv
`timescale 1ns/1ps
module pps_dds
    import pps_pkg::*;
#(
    parameter int unsigned ACC_W    = 32,
    parameter int unsigned UPD_FREQ = 1024,
    parameter int unsigned UPD_TIME = 65536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] word_in,
    input  logic             load,
    input  pps_mode_e        mode,
    output logic             synth_clk,
    output acc_evt_t         evt
);
    localparam int unsigned UW = cnt_w(max_u(UPD_FREQ, UPD_TIME));
    localparam logic [UW-1:0] LIM_F = UW'(UPD_FREQ - 1);
    localparam logic [UW-1:0] LIM_T = UW'(UPD_TIME - 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] act_q;
    logic [ACC_W-1:0] shadow_q;
    logic             pend_q;
    logic [ACC_W:0]   sum;
    logic             carry;
    logic             apply;
    logic [UW-1:0]    upd_cnt;
    logic [UW-1:0]    upd_lim;
    logic             upd_q;
    pps_mode_e        mode_d;

    assign sum     = {1'b0, acc_q} + {1'b0, act_q};
    assign carry   = sum[ACC_W];
    assign apply   = pend_q && (carry || (act_q == '0));
    assign upd_lim = (mode == MODE_TIME) ? LIM_T : LIM_F;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            act_q    <= '0;
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            acc_q <= sum[ACC_W-1:0];
            if (apply) begin
                act_q  <= shadow_q;
                pend_q <= 1'b0;
            end
            if (load) begin
                shadow_q <= word_in;
                pend_q   <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_cnt <= '0;
            upd_q   <= 1'b0;
            mode_d  <= MODE_FREQ;
        end else begin
            mode_d <= mode;
            upd_q  <= 1'b0;
            if (mode != mode_d) begin
                upd_cnt <= '0;
            end else if (carry) begin
                if (upd_cnt >= upd_lim) begin
                    upd_cnt <= '0;
                    upd_q   <= 1'b1;
                end else begin
                    upd_cnt <= upd_cnt + 1'b1;
                end
            end
        end
    end

    assign synth_clk = acc_q[ACC_W-1];
    assign evt.carry = carry;
    assign evt.req   = upd_q;

    AST_WORD_SAFE: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_q) |-> $past(pend_q && (carry || (act_q == '0))));  // R3
    AST_UPD_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
        upd_q |-> $past(carry));  // R8

endmodule

// File: rtl/pps_ref_div.sv
`timescale 1ns/1ps
module pps_ref_div #(
    parameter int unsigned DIV_A = 4000,
    parameter int unsigned DIV_B = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_async,
    output logic en,
    output logic tick
);
    localparam int unsigned AW = pps_pkg::cnt_w(DIV_A);
    localparam int unsigned BW = pps_pkg::cnt_w(DIV_B);
    localparam logic [AW-1:0] A_END = AW'(DIV_A - 1);
    localparam logic [BW-1:0] B_END = BW'(DIV_B - 1);

    logic          sync1, sync2;
    logic [AW-1:0] ca;
    logic [BW-1:0] cb;

    assign en = !sync2;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            ca    <= '0;
            cb    <= '0;
            tick  <= 1'b0;
        end else begin
            sync1 <= mode_async;
            sync2 <= sync1;
            tick  <= 1'b0;
            if (!en) begin
                ca <= '0;
                cb <= '0;
            end else if (ca == A_END) begin
                ca <= '0;
                if (cb == B_END) begin
                    cb   <= '0;
                    tick <= 1'b1;
                end else begin
                    cb <= cb + 1'b1;
                end
            end else begin
                ca <= ca + 1'b1;
            end
        end
    end

    AST_REF_HELD: assert property (@(posedge clk) disable iff (rst)
        !en |=> (ca == '0 && cb == '0));  // R6
    AST_REF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tick);  // R6

endmodule

// File: rtl/pps_time_path.sv
`timescale 1ns/1ps
module pps_time_path #(
    parameter int unsigned TIME_TC = 10000000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic wrap,
    output logic tick
);
    localparam int unsigned TW = pps_pkg::cnt_w(TIME_TC + 2);
    localparam logic [TW-1:0] TC_V = TW'(TIME_TC);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] nxt;

    assign nxt = cnt_q + TW'(1) + {{(TW-1){1'b0}}, wrap};

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (nxt >= TC_V) begin
            cnt_q <= nxt - TC_V;
            tick  <= 1'b1;
        end else begin
            cnt_q <= nxt;
            tick  <= 1'b0;
        end
    end

    AST_TIME_QUIET: assert property (@(posedge clk) disable iff (rst)
        !active |=> (!tick && cnt_q == '0));  // R6
    AST_TIME_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);  // R5

endmodule

// File: rtl/dual_pps_gen.sv
`timescale 1ns/1ps
module dual_pps_gen
    import pps_pkg::*;
#(
    parameter int unsigned ACC_W    = 32,
    parameter int unsigned DIV_A    = 4000,
    parameter int unsigned DIV_B    = 2500,
    parameter int unsigned TIME_TC  = 10000000,
    parameter int unsigned PULSE_W  = 100,
    parameter int unsigned UPD_FREQ = 1024,
    parameter int unsigned UPD_TIME = 65536
) (
    input  logic             clk_ovt,
    input  logic             clk_ref,
    input  logic             rst,
    input  logic [ACC_W-1:0] corr_word,
    input  logic             corr_load,
    input  logic             mode_time,
    output logic             synth_clk,
    output logic             pps,
    output logic             pll_en,
    output logic             ref_div_en,
    output logic             upd_req
);
    pps_mode_e mode_q;
    acc_evt_t  evt;
    logic      ref_tick, time_tick;
    logic      ref_pulse, time_pulse;
    logic      time_on;

    always_ff @(posedge clk_ovt) begin
        if (rst) mode_q <= MODE_FREQ;
        else     mode_q <= pps_mode_e'(mode_time);
    end

    assign time_on = (mode_q == MODE_TIME);
    assign pll_en  = !time_on;

    pps_dds #(.ACC_W(ACC_W), .UPD_FREQ(UPD_FREQ), .UPD_TIME(UPD_TIME)) dds_i (
        .clk(clk_ovt), .rst(rst), .word_in(corr_word), .load(corr_load),
        .mode(mode_q), .synth_clk(synth_clk), .evt(evt)
    );

    assign upd_req = evt.req;

    pps_time_path #(.TIME_TC(TIME_TC)) tpath_i (
        .clk(clk_ovt), .rst(rst), .active(time_on), .wrap(evt.carry),
        .tick(time_tick)
    );

    pps_ref_div #(.DIV_A(DIV_A), .DIV_B(DIV_B)) rdiv_i (
        .clk(clk_ref), .rst(rst), .mode_async(mode_q == MODE_TIME),
        .en(ref_div_en), .tick(ref_tick)
    );

    pps_stretch #(.WIDTH(PULSE_W)) st_ref_i (
        .clk(clk_ref), .rst(rst), .clr(!ref_div_en), .tick(ref_tick),
        .pulse(ref_pulse)
    );

    pps_stretch #(.WIDTH(PULSE_W)) st_time_i (
        .clk(clk_ovt), .rst(rst), .clr(!time_on), .tick(time_tick),
        .pulse(time_pulse)
    );

    assign pps = ref_pulse | time_pulse;

endmodule

// File: tb/dual_pps_gen_tb_top.sv
`timescale 1ns/1ps
module dual_pps_gen_tb_top;
    localparam int ACC_W = 32;

    logic             clk_ovt = 1'b0;
    logic             clk_ref = 1'b0;
    logic             rst = 1'b1;
    logic [ACC_W-1:0] corr_word = '0;
    logic             corr_load = 1'b0;
    logic             mode_time = 1'b0;
    logic             synth_clk, pps, pll_en, ref_div_en, upd_req;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk_ovt = ~clk_ovt;
    always #8  clk_ref = ~clk_ref;

    dual_pps_gen #(
        .ACC_W(ACC_W), .DIV_A(4), .DIV_B(5), .TIME_TC(40),
        .PULSE_W(3), .UPD_FREQ(4), .UPD_TIME(16)
    ) dut_i (
        .clk_ovt(clk_ovt), .clk_ref(clk_ref), .rst(rst),
        .corr_word(corr_word), .corr_load(corr_load), .mode_time(mode_time),
        .synth_clk(synth_clk), .pps(pps), .pll_en(pll_en),
        .ref_div_en(ref_div_en), .upd_req(upd_req)
    );

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pps_rise(output longint t);
        @(posedge pps); t = longint'($time);
    endtask
    task automatic pps_fall(output longint t);
        @(negedge pps); t = longint'($time);
    endtask
    task automatic synth_rise(output longint t);
        @(posedge synth_clk); t = longint'($time);
    endtask
    task automatic upd_rise(output longint t);
        @(posedge upd_req); t = longint'($time);
    endtask

    task automatic load_word(input logic [ACC_W-1:0] w);
        @(negedge clk_ovt); corr_word = w; corr_load = 1'b1;
        @(negedge clk_ovt); corr_load = 1'b0;
    endtask

    task automatic t_reset;
        repeat (12) @(negedge clk_ovt);
        rst = 1'b0;
        @(negedge clk_ovt);
        check("R1 pps", pps == 1'b0, pps, 0);
        check("R1 synth_clk", synth_clk == 1'b0, synth_clk, 0);
        check("R1 upd_req", upd_req == 1'b0, upd_req, 0);
        check("R1 pll_en", pll_en == 1'b1, pll_en, 1);
        check("R1 ref_div_en", ref_div_en == 1'b1, ref_div_en, 1);
    endtask

    task automatic t_freq_mode;
        longint a, f, b;
        pps_rise(a); pps_fall(f); pps_rise(b);
        check("R10 freq width", (f - a) == 48, f - a, 48);
        check("R4 R7 freq period", (b - a) == 320, b - a, 320);
    endtask

    task automatic t_to_timing;
        longint t0, a, f, b;
        @(negedge pps);
        @(negedge clk_ovt); mode_time = 1'b1; t0 = longint'($time);
        #100;
        check("R6 R7 pll_en off", pll_en == 1'b0, pll_en, 0);
        check("R6 ref_div_en off", ref_div_en == 1'b0, ref_div_en, 0);
        pps_rise(a);
        check("R9 first timing pulse delay", (a - t0) >= 800 && (a - t0) <= 860, a - t0, 830);
        pps_fall(f); pps_rise(b);
        check("R10 timing width", (f - a) == 60, f - a, 60);
        check("R5 R6 timing period word 0", (b - a) == 800, b - a, 800);
    endtask

    task automatic t_load_timing;
        longint a, b, c;
        load_word(32'h4000_0000);
        synth_rise(a); synth_rise(b);
        check("R2 R3 synth period word 2^30", (b - a) == 80, b - a, 80);
        pps_rise(a); pps_rise(b); pps_rise(c);
        check("R5 timing period with wraps", (c - b) == 640, c - b, 640);
        upd_rise(a); upd_rise(b); upd_rise(c);
        check("R8 timing update spacing", (c - b) == 1280, c - b, 1280);
    endtask

    task automatic t_to_freq;
        longint t0, a, b, c;
        @(negedge pps);
        @(negedge clk_ovt); mode_time = 1'b0; t0 = longint'($time);
        #100;
        check("R7 pll_en on", pll_en == 1'b1, pll_en, 1);
        check("R6 ref_div_en on", ref_div_en == 1'b1, ref_div_en, 1);
        pps_rise(a);
        check("R9 first freq pulse delay", (a - t0) >= 320 && (a - t0) <= 400, a - t0, 350);
        pps_rise(b);
        check("R4 freq period after return", (b - a) == 320, b - a, 320);
        upd_rise(a); upd_rise(b); upd_rise(c);
        check("R8 freq update spacing", (c - b) == 320, c - b, 320);
    endtask

    task automatic t_word_swap;
        longint a, b;
        load_word(32'h8000_0000);
        repeat (10) @(negedge clk_ovt);
        synth_rise(a); synth_rise(b);
        check("R3 R2 new word after wrap", (b - a) == 40, b - a, 40);
    endtask

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_freq_mode();
        t_to_timing();
        t_load_timing();
        t_to_freq();
        t_word_swap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule